// File: doc/BRIEF.md
# Up/Down Potentiometer Positioning Sequencer

This block is the host-side master for a 64-position digital potentiometer that is steered over three control wires: an active-low select, an active-low increment strobe and a direction level. A client hands it a target position together with a save flag. The block keeps the position it believes the wiper holds, works out how many increment strobes are needed and in which direction, and plays them out. It then ends the session. When the save flag is set, the strobe is returned high before the select is released, so the part stores the position in its non-volatile cell. When the flag is clear, the strobe is held low across the release, so nothing is stored.

Every interface interval is a count of clock cycles. Each count comes from a nanosecond parameter and the clock period, rounded up. Examples are the wait after power-up, select-to-strobe setup, direction setup, strobe low and high widths, the strobe-high time before a storing release, and the two deselect times. A calibrate request sends one full-range burst of downward strobes. Because the believed position saturates, it then reads zero, whatever it held before.

Top module: `pot_seq_master`

## Requirements
- R1: From reset, busy is 1 and select and strobe are both 1 (inactive). No select is driven for the power-up interval (PUD_C cycles). After that interval busy falls to 0.
- R2: A request seen at a clock edge while idle drives select low (0) and busy high from that same edge. The direction output is set at that edge: 1 = up toward the A end, 0 = down.
- R3: A normal request produces exactly |target − believed position| strobe falls. Direction is 1 when the target is larger and 0 otherwise.
- R4: The believed position (cur_pos) changes only on a strobe fall, by one step in the direction shown, and saturates at 0 and 63. After a move it equals the target.
- R5: The first strobe fall of a session comes no fewer than CI_C cycles after select falls. The direction output holds steady for the whole time select is low.
- R6: Each strobe low phase lasts at least IL_C cycles. Each strobe high phase between two falls of one session lasts at least IH_C cycles.
- R7: With save set, the strobe is 1 when select rises, having been high for at least IC_C cycles. Select then stays high for at least SAVE_C cycles before done.
- R8: With save clear, the strobe is 0 when select rises. Select then stays high for at least CPH_C cycles before done.
- R9: A request whose target equals the believed position, with save clear, drives no select. Done pulses one cycle after the edge that saw the request.
- R10: A request made while busy is ignored: it changes neither the pulse count, the direction, nor the final position.
- R11: Done is a single-cycle pulse, raised in the same cycle that busy is 0.
- R12: A calibrate request issues exactly 64 downward strobe falls and leaves cur_pos at 0, including when it already was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_pos | input | POS_W | Target position |
| req_save | input | 1 | 1 = store the position in the part's non-volatile cell at session end |
| req_cal | input | 1 | 1 = calibrate: full-range downward burst, target ignored |
| busy | output | 1 | Power-up wait or session in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Active-low select to the potentiometer |
| inc_n | output | 1 | Active-low increment strobe; a falling edge moves the wiper |
| up_dn | output | 1 | Direction: 1 = toward A end, 0 = toward B end |
| cur_pos | output | POS_W | Believed wiper position |

## Verification
Select, busy and direction come from registers loaded at the edge that accepts a request. They are therefore read at the falling clock edge just after that edge. Strobe falls and position updates share one edge, so a monitor sampling every falling clock edge counts falls, the direction at each fall, and the low and select runs in whole cycles. Done is due one cycle after the request edge for an empty request. Otherwise it is due a full deselect interval after select rises. The bench stamps both events with its cycle counter and compares the gap against the save or no-save minimum, rather than waiting a fixed time.

// File: rtl/pot_seq_pkg.sv
package pot_seq_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP,
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_HOLD,
      ST_RELNS,
      ST_DESEL
   } seq_state_t;

   // nanoseconds to clock cycles, rounded up
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
      longint unsigned num;
      longint unsigned res;
      num = longint'(ns) * 64'd1000 + longint'(clk_ps) - 64'd1;
      res = num / longint'(clk_ps);
      return res[31:0];
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pot_timer.sv
module pot_timer #(
   parameter int unsigned W       = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= W'(RST_VAL);
      end else if (load) begin
         cnt <= val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/pot_step_calc.sv
module pot_step_calc #(
   parameter int unsigned POS_W  = 6,
   parameter bit          CAL_EN = 1'b1
) (
   input  logic [POS_W-1:0] cur,
   input  logic [POS_W-1:0] tgt,
   input  logic             cal,
   output logic [POS_W:0]   steps,
   output logic             up
);
   localparam logic [POS_W:0] FULL_RANGE = (POS_W+1)'(1) << POS_W;

   logic             tgt_gt;
   logic [POS_W-1:0] mag;

   always_comb begin
      tgt_gt = (tgt > cur);
      mag    = tgt_gt ? (tgt - cur) : (cur - tgt);
   end

   generate
      if (CAL_EN) begin : g_cal
         always_comb begin
            if (cal) begin
               steps = FULL_RANGE;
               up    = 1'b0;
            end else begin
               steps = {1'b0, mag};
               up    = tgt_gt;
            end
         end
      end else begin : g_nocal
         logic cal_unused;
         assign cal_unused = cal;
         always_comb begin
            steps = {cal_unused & 1'b0, mag};
            up    = tgt_gt;
         end
      end
   endgenerate
endmodule

// File: rtl/pot_pos_track.sv
module pot_pos_track #(
   parameter int unsigned POS_W     = 6,
   parameter int unsigned RESET_POS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             up,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] POS_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= POS_W'(RESET_POS);
      end else if (step) begin
         if (up) begin
            if (pos != POS_MAX) pos <= pos + 1'b1;
         end else begin
            if (pos != '0) pos <= pos - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pot_seq_master.sv
module pot_seq_master
   import pot_seq_pkg::*;
#(
   parameter int unsigned POS_W      = 6,
   parameter int unsigned RESET_POS  = 32,
   parameter bit          CAL_EN     = 1'b1,
   parameter int unsigned CLK_PS     = 10000,
   parameter int unsigned T_PUD_NS   = 1000000,
   parameter int unsigned T_CI_NS    = 100,
   parameter int unsigned T_DI_NS    = 50,
   parameter int unsigned T_ID_NS    = 100,
   parameter int unsigned T_IL_NS    = 250,
   parameter int unsigned T_IH_NS    = 250,
   parameter int unsigned T_IC_NS    = 1000,
   parameter int unsigned T_CPH_NS   = 100,
   parameter int unsigned T_SAVE_NS  = 10000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [POS_W-1:0] req_pos,
   input  logic             req_save,
   input  logic             req_cal,
   output logic             busy,
   output logic             done,
   output logic             cs_n,
   output logic             inc_n,
   output logic             up_dn,
   output logic [POS_W-1:0] cur_pos
);
   // interval lengths in cycles, each at least one
   localparam int unsigned PUD_C   = umax(1, ns2cyc(T_PUD_NS, CLK_PS));
   localparam int unsigned CI_C    = umax(1, ns2cyc(T_CI_NS, CLK_PS));
   localparam int unsigned DI_C    = umax(1, ns2cyc(T_DI_NS, CLK_PS));
   localparam int unsigned ID_C    = umax(1, ns2cyc(T_ID_NS, CLK_PS));
   localparam int unsigned IL_C    = umax(1, ns2cyc(T_IL_NS, CLK_PS));
   localparam int unsigned IH_C    = umax(1, ns2cyc(T_IH_NS, CLK_PS));
   localparam int unsigned IC_C    = umax(1, ns2cyc(T_IC_NS, CLK_PS));
   localparam int unsigned CPH_C   = umax(1, ns2cyc(T_CPH_NS, CLK_PS));
   localparam int unsigned SAVE_C  = umax(1, ns2cyc(T_SAVE_NS, CLK_PS));
   localparam int unsigned SETUP_C = umax(CI_C, DI_C);
   localparam int unsigned HOLD_C  = umax(IH_C, IC_C);
   localparam int unsigned DESN_C  = umax(CPH_C, ID_C);
   localparam int unsigned DESS_C  = umax(SAVE_C, ID_C);
   localparam int unsigned MAX_C   = umax(umax(umax(PUD_C, SETUP_C), umax(HOLD_C, DESN_C)),
                                          umax(umax(DESS_C, IL_C), IH_C));
   localparam int unsigned TMR_W   = $clog2(MAX_C + 1);

   // elaboration-time parameter checks
   generate
      if (POS_W < 2 || POS_W > 12) begin : g_bad_posw
         $error("pot_seq_master: POS_W out of range");
      end
      if (RESET_POS >= (1 << POS_W)) begin : g_bad_rstpos
         $error("pot_seq_master: RESET_POS exceeds position range");
      end
      if (CLK_PS == 0) begin : g_bad_clk
         $error("pot_seq_master: CLK_PS must be nonzero");
      end
   endgenerate

   seq_state_t       state, state_d;
   logic [POS_W:0]   steps_q;
   logic             save_q;
   logic             up_q;
   logic             cs_n_q, inc_n_q, busy_q, done_q;

   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_zero;

   logic             accept, trivial, fin, step;
   logic [POS_W:0]   calc_steps;
   logic             calc_up;
   logic             sel_d, inc_lo_d;

   pot_timer #(.W(TMR_W), .RST_VAL(PUD_C - 1)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .val   (tmr_val),
      .zero  (tmr_zero)
   );

   pot_step_calc #(.POS_W(POS_W), .CAL_EN(CAL_EN)) u_calc (
      .cur   (cur_pos),
      .tgt   (req_pos),
      .cal   (req_cal),
      .steps (calc_steps),
      .up    (calc_up)
   );

   pot_pos_track #(.POS_W(POS_W), .RESET_POS(RESET_POS)) u_pos (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .up    (up_q),
      .pos   (cur_pos)
   );

   always_comb begin
      state_d  = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      step     = 1'b0;
      accept   = 1'b0;
      trivial  = 1'b0;
      fin      = 1'b0;
      unique case (state)
         ST_PWRUP: begin
            if (tmr_zero) state_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (req_valid) begin
               accept = 1'b1;
               if (calc_steps == '0 && !req_save) begin
                  trivial = 1'b1;
               end else begin
                  state_d  = ST_SETUP;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(SETUP_C - 1);
               end
            end
         end
         ST_SETUP: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (steps_q == '0) begin
                  state_d = ST_HOLD;
                  tmr_val = TMR_W'(HOLD_C - 1);
               end else begin
                  state_d = ST_LOW;
                  tmr_val = TMR_W'(IL_C - 1);
                  step    = 1'b1;
               end
            end
         end
         ST_LOW: begin
            if (tmr_zero) begin
               if (steps_q != '0) begin
                  state_d  = ST_HIGH;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(IH_C - 1);
               end else if (save_q) begin
                  state_d  = ST_HOLD;
                  tmr_load = 1'b1;
                  tmr_val  = TMR_W'(HOLD_C - 1);
               end else begin
                  state_d  = ST_RELNS;
               end
            end
         end
         ST_HIGH: begin
            if (tmr_zero) begin
               state_d  = ST_LOW;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(IL_C - 1);
               step     = 1'b1;
            end
         end
         ST_HOLD: begin
            if (tmr_zero) begin
               state_d  = ST_DESEL;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(DESS_C - 1);
            end
         end
         ST_RELNS: begin
            state_d  = ST_DESEL;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(DESN_C - 1);
         end
         ST_DESEL: begin
            if (tmr_zero) begin
               state_d = ST_IDLE;
               fin     = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      sel_d    = (state_d == ST_SETUP) || (state_d == ST_LOW) ||
                 (state_d == ST_HIGH)  || (state_d == ST_HOLD);
      inc_lo_d = (state_d == ST_LOW) || (state_d == ST_RELNS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_PWRUP;
         steps_q <= '0;
         save_q  <= 1'b0;
         up_q    <= 1'b0;
         cs_n_q  <= 1'b1;
         inc_n_q <= 1'b1;
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         state <= state_d;
         if (accept) begin
            steps_q <= calc_steps;
            save_q  <= req_save;
            up_q    <= calc_up;
         end else if (step) begin
            steps_q <= steps_q - 1'b1;
         end
         cs_n_q  <= !sel_d;
         inc_n_q <= !inc_lo_d;
         busy_q  <= (state_d != ST_IDLE);
         done_q  <= trivial || fin;
      end
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign cs_n  = cs_n_q;
   assign inc_n = inc_n_q;
   assign up_dn = up_q;
endmodule

// File: rtl/pot_seq_chk.sv
module pot_seq_chk #(
   parameter int unsigned POS_W  = 6,
   parameter int unsigned CW     = 8,
   parameter int unsigned PUD_C  = 1,
   parameter int unsigned CI_C   = 1,
   parameter int unsigned IL_C   = 1,
   parameter int unsigned IH_C   = 1,
   parameter int unsigned IC_C   = 1,
   parameter int unsigned CPH_C  = 1,
   parameter int unsigned SAVE_C = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             inc_n,
   input logic             up_dn,
   input logic             busy,
   input logic             done,
   input logic [POS_W-1:0] cur_pos
);
   logic [CW-1:0] sel_cnt, lo_cnt, hi_cnt, des_cnt;
   logic          cs_q, inc_q, last_saved, ever_sel, fell_seen;

   function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
      return (v == '1) ? v : v + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_cnt    <= '0;
         lo_cnt     <= '0;
         hi_cnt     <= '0;
         des_cnt    <= '0;
         cs_q       <= 1'b1;
         inc_q      <= 1'b1;
         last_saved <= 1'b0;
         ever_sel   <= 1'b0;
         fell_seen  <= 1'b0;
      end else begin
         sel_cnt  <= cs_n ? '0 : sat_inc(sel_cnt);
         des_cnt  <= cs_n ? sat_inc(des_cnt) : '0;
         lo_cnt   <= inc_n ? '0 : sat_inc(lo_cnt);
         hi_cnt   <= inc_n ? sat_inc(hi_cnt) : '0;
         cs_q     <= cs_n;
         inc_q    <= inc_n;
         ever_sel <= ever_sel | !cs_n;
         if (!cs_q && cs_n) last_saved <= inc_n;
         if (cs_n) fell_seen <= 1'b0;
         else if (inc_q && !inc_n) fell_seen <= 1'b1;
      end
   end

   AST_PWRUP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && !ever_sel) |-> (des_cnt >= CW'(PUD_C))); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && inc_n)); // R2
   AST_POS_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(inc_n) |-> $stable(cur_pos)); // R4
   AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inc_n) |-> (!cs_n && sel_cnt >= CW'(CI_C))); // R5
   AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> $stable(up_dn)); // R5
   AST_INC_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inc_n) |-> (lo_cnt >= CW'(IL_C))); // R6
   AST_INC_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(inc_n) && fell_seen) |-> (hi_cnt >= CW'(IH_C))); // R6
   AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cs_n) && inc_n) |-> (hi_cnt >= CW'(IC_C))); // R7
   AST_DESEL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && ever_sel) |-> (des_cnt >= (last_saved ? CW'(SAVE_C) : CW'(CPH_C)))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R11
endmodule

bind pot_seq_master pot_seq_chk #(
   .POS_W (POS_W),
   .CW    (TMR_W + 1),
   .PUD_C (PUD_C),
   .CI_C  (CI_C),
   .IL_C  (IL_C),
   .IH_C  (IH_C),
   .IC_C  (IC_C),
   .CPH_C (CPH_C),
   .SAVE_C(SAVE_C)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_n   (cs_n),
   .inc_n  (inc_n),
   .up_dn  (up_dn),
   .busy   (busy),
   .done   (done),
   .cur_pos(cur_pos)
);

// File: tb/tb_pot_seq_master.sv
`timescale 1ns/1ps
module tb_pot_seq_master;
   localparam int CLK_PS = 10000;
   localparam int PUD_C  = (3000 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int CI_C   = (100 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int IL_C   = (250 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int CPH_C  = (100 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int SAVE_C = (4000 * 1000 + CLK_PS - 1) / CLK_PS;
   localparam int WD_LIM = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [5:0] req_pos = '0;
   logic       req_save = 1'b0;
   logic       req_cal = 1'b0;
   logic       busy, done, cs_n, inc_n, up_dn;
   logic [5:0] cur_pos;

   always #5 clk = ~clk;

   pot_seq_master #(
      .POS_W(6), .RESET_POS(32), .CLK_PS(CLK_PS),
      .T_PUD_NS(3000), .T_SAVE_NS(4000)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pos(req_pos),
      .req_save(req_save), .req_cal(req_cal), .busy(busy), .done(done),
      .cs_n(cs_n), .inc_n(inc_n), .up_dn(up_dn), .cur_pos(cur_pos)
   );

   int n_chk = 0, n_err = 0;
   int cyc = 0;
   int fall_cnt, dir_err, unsel_fall, setup_err, low_err, done_cnt;
   int sel_run = 0, low_run = 0;
   int rise_cyc, done_cyc, req_cyc;
   bit sel_seen, rel_inc, exp_up;
   bit p_inc = 1'b1, p_cs = 1'b1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_stats();
      fall_cnt = 0; dir_err = 0; unsel_fall = 0; setup_err = 0;
      low_err = 0; done_cnt = 0; sel_seen = 0; rel_inc = 0;
      rise_cyc = 0; done_cyc = 0; req_cyc = 0;
   endtask

   // monitor, sampling at the falling clock edge
   always @(negedge clk) begin
      cyc++;
      if (req_valid && !busy) req_cyc = cyc;
      if (p_inc && !inc_n) begin
         fall_cnt++;
         if (up_dn != exp_up) dir_err++;
         if (cs_n) unsel_fall++;
         if (fall_cnt == 1 && sel_run < CI_C) setup_err++;
      end
      if (!p_inc && inc_n && low_run < IL_C) low_err++;
      low_run = inc_n ? 0 : low_run + 1;
      sel_run = cs_n ? 0 : sel_run + 1;
      if (p_cs && !cs_n) sel_seen = 1;
      if (!p_cs && cs_n) begin rel_inc = inc_n; rise_cyc = cyc; end
      if (done) begin done_cnt++; done_cyc = cyc; end
      p_inc = inc_n;
      p_cs  = cs_n;
      if (cyc == WD_LIM) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=<%0d", cyc, WD_LIM);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic run_move(input string tag, input logic [5:0] tgt, input bit sv, input bit cal,
                           input int exp_n, input bit e_up, input int exp_pos,
                           input bit exp_sel, input bit spam);
      int waited;
      clear_stats();
      exp_up = e_up;
      @(posedge clk); #2;
      req_pos = tgt; req_save = sv; req_cal = cal; req_valid = 1'b1;
      @(posedge clk); #2;
      req_valid = 1'b0; req_cal = 1'b0;
      @(negedge clk); #1;
      if (exp_sel) begin
         chk(busy && !cs_n, {tag, " R2 select and busy after accept"}, {busy, cs_n}, 2'b10);
      end
      if (spam) begin
         repeat (40) @(posedge clk);
         #2; req_pos = ~tgt; req_save = ~sv; req_valid = 1'b1;
         @(posedge clk); #2; req_valid = 1'b0; req_pos = tgt;
      end
      waited = 0;
      while (done_cnt == 0 && waited < 20000) begin
         @(negedge clk); #1;
         waited++;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(done_cnt == 1, {tag, " R11 single done pulse"}, done_cnt, 1);
      chk(!busy, {tag, " R11 busy low after done"}, busy, 0);
      chk(fall_cnt == exp_n, {tag, " R3 strobe fall count"}, fall_cnt, exp_n);
      chk(dir_err == 0 && unsel_fall == 0, {tag, " R3 direction at falls"}, dir_err, 0);
      chk(cur_pos == 6'(exp_pos), {tag, " R4 final position"}, cur_pos, exp_pos);
      chk(sel_seen == exp_sel, {tag, " R9 selection occurred"}, sel_seen, exp_sel);
      if (exp_sel) begin
         chk(rel_inc == sv, sv ? {tag, " R7 strobe high at release"} : {tag, " R8 strobe low at release"},
             rel_inc, sv);
         chk(done_cyc - rise_cyc >= (sv ? SAVE_C : CPH_C),
             sv ? {tag, " R7 save deselect time"} : {tag, " R8 deselect time"},
             done_cyc - rise_cyc, sv ? SAVE_C : CPH_C);
         chk(setup_err == 0, {tag, " R5 select to first fall"}, setup_err, 0);
         chk(low_err == 0, {tag, " R6 strobe low width"}, low_err, 0);
      end else begin
         chk(done_cyc - req_cyc == 1, {tag, " R9 done latency"}, done_cyc - req_cyc, 1);
      end
   endtask

   initial begin
      clear_stats();
      exp_up = 0;
      repeat (5) @(negedge clk);
      chk(cs_n && inc_n && busy, "R1 reset outputs", {cs_n, inc_n, busy}, 3'b111);
      @(posedge clk); #2;
      rst_n = 1'b1;
      // request during power-up must be ignored (R10)
      repeat (20) @(posedge clk);
      #2; req_pos = 6'd5; req_valid = 1'b1;
      @(posedge clk); #2; req_valid = 1'b0;
      repeat (PUD_C - 40) @(negedge clk);
      #1;
      chk(busy && cs_n, "R1 still waiting before power-up interval", {busy, cs_n}, 2'b11);
      repeat (40) @(negedge clk);
      #1;
      chk(!busy, "R1 busy low after power-up interval", busy, 0);
      chk(!sel_seen && fall_cnt == 0, "R10 request during power-up ignored", fall_cnt, 0);
      chk(cur_pos == 6'd32, "R10 position untouched by ignored request", cur_pos, 32);

      run_move("cal",      6'd50, 1'b0, 1'b1, 64, 1'b0, 0,  1'b1, 1'b0); // R12
      run_move("up40sv",   6'd40, 1'b1, 1'b0, 40, 1'b1, 40, 1'b1, 1'b0); // R7
      run_move("same40",   6'd40, 1'b0, 1'b0, 0,  1'b0, 40, 1'b0, 1'b0); // R9
      run_move("dn10busy", 6'd10, 1'b0, 1'b0, 30, 1'b0, 10, 1'b1, 1'b1); // R10
      run_move("up63sv",   6'd63, 1'b1, 1'b0, 53, 1'b1, 63, 1'b1, 1'b0); // R4
      run_move("same63sv", 6'd63, 1'b1, 1'b0, 0,  1'b0, 63, 1'b1, 1'b0); // R7
      run_move("dn0",      6'd0,  1'b0, 1'b0, 63, 1'b0, 0,  1'b1, 1'b0); // R8
      run_move("cal_at0",  6'd9,  1'b1, 1'b1, 64, 1'b0, 0,  1'b1, 1'b0); // R12
      run_move("up1",      6'd1,  1'b0, 1'b0, 1,  1'b1, 1,  1'b1, 1'b0); // R3

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule